// File: doc/BRIEF.md
# Cache Way Lockdown Victim Selector

This block picks which way of a four-way set-associative cache receives the next linefill. A small lock register holds one bit per way. A way whose bit is set is locked: it is never chosen as a victim and keeps the lines already in it. The remaining open ways share allocation in round-robin order. This lets software pin critical code or data in the locked ways while normal replacement continues in the open ones.

A cache controller pulses `fill_req` for one cycle per linefill. One cycle later the block returns the chosen way on `fill_way` together with a one-cycle `fill_valid` strobe. The lock register is written and read through a plain register port. If every way is locked, the block sends all linefills to the highest way (way 3). This keeps replacement working even when software breaks the rule of leaving at least one way open.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset the lock register is zero (all four ways open), `reg_rdata` is zero and `fill_valid` is low.
- R2: A cycle with `reg_wr_en` high loads `reg_wdata[3:0]` into the lock register. Bit n locks way n (1 = locked, 0 = open). `reg_rdata` returns the lock bits in bits 3..0, and all higher bits read as zero whatever was written to them.
- R3: `fill_valid` is high in exactly the cycle after each cycle in which `fill_req` is high, and low otherwise.
- R4: When at least one way is open, the granted way is always an open way.
- R5: When all four lock bits are set, every grant selects way 3.
- R6: A round-robin pointer starts at way 0 after reset. The chosen way is the first open way found by searching upward from the pointer and wrapping from way 3 to way 0. After each grant the pointer moves to the granted way plus one, modulo 4.
- R7: A lock write in the same cycle as `fill_req` does not affect that request. The request is resolved with the lock bits held before the write, and the new bits apply from the next request onward.
- R8: Requests in consecutive cycles are each granted, one grant per cycle, with no lost or merged requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Write strobe for the lock register |
| reg_wdata | input | 32 | Write data; only bits 3..0 are stored |
| reg_rdata | output | 32 | Lock register read value, upper bits zero |
| fill_req | input | 1 | One linefill request per high cycle |
| fill_valid | output | 1 | Grant strobe, one cycle after the request |
| fill_way | output | 2 | Granted way index, valid while `fill_valid` is high |

## Verification
The bench uses the default parameters: four ways and a 32-bit register port. With only four ways, a short sequence walks the pointer through every wrap position and covers every lock pattern of interest: all open, alternate ways, a single open way, and fully locked. Because the register is 32 bits wide, junk written into the upper bits shows whether they are discarded. The scoreboard predicts each grant from the lock bits and pointer in effect at the request edge, so same-cycle writes and back-to-back requests are checked one cycle at a time.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);
  typedef logic [NUM_WAYS-1:0] lock_mask_t;
  typedef logic [WAY_W-1:0]    way_idx_t;
endpackage

// File: rtl/vsel_rst_sync.sv
module vsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/vsel_lock_reg.sv
module vsel_lock_reg #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic [NUM_WAYS-1:0] lock_mask
);
  localparam int unsigned PAD_W = REG_W - NUM_WAYS;

  logic [NUM_WAYS-1:0] lock_q;
  logic [NUM_WAYS-1:0] lock_d;

  always_comb begin
    lock_d = lock_q;
    if (wr_en) lock_d = wdata[NUM_WAYS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  assign lock_mask = lock_q;
  assign rdata     = {{PAD_W{1'b0}}, lock_q};

  // R2: a write loads the low bits; without a write the mask holds
  p_lock_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lock_mask == $past(wdata[NUM_WAYS-1:0]));
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lock_mask));
endmodule

// File: rtl/vsel_rr_pick.sv
module vsel_rr_pick #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned WAY_W    = 2
) (
  input  logic [NUM_WAYS-1:0] lock_mask,
  input  logic [WAY_W-1:0]    start_ptr,
  output logic [WAY_W-1:0]    pick_way
);
  localparam logic [WAY_W-1:0] FALLBACK = WAY_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] cand;
  logic             found;

  always_comb begin
    pick_way = FALLBACK;
    found    = 1'b0;
    cand     = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      cand = start_ptr + WAY_W'(i);
      if (!found && !lock_mask[cand]) begin
        pick_way = cand;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsel_grant.sv
module vsel_grant #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned WAY_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_req,
  input  logic [NUM_WAYS-1:0] lock_mask,
  input  logic [WAY_W-1:0]    pick_way,
  output logic [WAY_W-1:0]    ptr,
  output logic                fill_valid,
  output logic [WAY_W-1:0]    fill_way
);
  localparam logic [WAY_W-1:0]    FALLBACK = WAY_W'(NUM_WAYS - 1);
  localparam logic [NUM_WAYS-1:0] ONE      = NUM_WAYS'(1);

  logic [WAY_W-1:0] ptr_q, ptr_d;
  logic [WAY_W-1:0] way_q, way_d;
  logic             vld_q, vld_d;
  logic             adv_en;

  assign adv_en = fill_req;

  always_comb begin
    ptr_d = ptr_q;
    way_d = way_q;
    vld_d = fill_req;
    if (adv_en) begin
      way_d = pick_way;
      ptr_d = pick_way + WAY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      way_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (adv_en) begin
        ptr_q <= ptr_d;
        way_q <= way_d;
      end
    end
  end

  assign ptr        = ptr_q;
  assign fill_valid = vld_q;
  assign fill_way   = way_q;

  // R3: one strobe per request, one cycle later
  p_req_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> fill_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_req |=> !fill_valid);
  // R4: never a locked way while an open one exists
  p_open_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !(&$past(lock_mask)) |->
      (($past(lock_mask) >> fill_way) & ONE) == '0);
  // R5: fully locked sends the fill to the top way
  p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && (&$past(lock_mask)) |-> fill_way == FALLBACK);
  // R6: pointer sits just past the last grant
  p_ptr_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> ptr == fill_way + WAY_W'(1));
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import vsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fill_req,
  output logic             fill_valid,
  output logic [WAY_W-1:0] fill_way
);
  logic       rst_sync_n;
  lock_mask_t lock_mask;
  way_idx_t   ptr;
  way_idx_t   pick_way;

  vsel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vsel_lock_reg #(.NUM_WAYS(NUM_WAYS), .REG_W(REG_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr_en),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .lock_mask (lock_mask)
  );

  vsel_rr_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
    .lock_mask (lock_mask),
    .start_ptr (ptr),
    .pick_way  (pick_way)
  );

  vsel_grant #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_grant (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fill_req   (fill_req),
    .lock_mask  (lock_mask),
    .pick_way   (pick_way),
    .ptr        (ptr),
    .fill_valid (fill_valid),
    .fill_way   (fill_way)
  );
endmodule

// File: tb/cache_victim_sel_tb.sv
module cache_victim_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        fill_req;
  logic        fill_valid;
  logic [1:0]  fill_way;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  logic [3:0] m_lock;
  int m_ptr;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_victim_sel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fill_req(fill_req), .fill_valid(fill_valid),
    .fill_way(fill_way)
  );

  function automatic int predict(input logic [3:0] lk, input int p);
    if (lk == 4'hF) return 3;
    for (int i = 0; i < 4; i++) begin
      if (!lk[(p + i) % 4]) return (p + i) % 4;
    end
    return 3;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus; pushes the predicted grant
  task automatic step(input bit req, input bit wr, input logic [31:0] wd, input string tag);
    @(negedge clk);
    fill_req  = req;
    reg_wr_en = wr;
    reg_wdata = wd;
    if (req) begin
      int w;
      w = predict(m_lock, m_ptr);
      exp_q.push_back(w);
      tag_q.push_back(tag);
      m_ptr = (w + 1) % 4;
    end
    if (wr) m_lock = wd[3:0];
  endtask

  task automatic check_read(input string tag);
    @(negedge clk);
    check(tag, reg_rdata == {28'h0, m_lock}, int'(reg_rdata), int'(m_lock));
  endtask

  // monitor: compares grants one cycle after each request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
        if (fill_valid) begin
          if (exp_q.size() == 0) begin
            check("R3 spurious grant", 1'b0, 1, 0);
          end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(fill_way) == e, int'(fill_way), e);
          end
        end else if (exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          check("R3 missing grant", 1'b0, 0, 1);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; fill_req = 1'b0;
    m_lock = '0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata == 32'h0, int'(reg_rdata), 0);
    check("R1 valid", fill_valid == 1'b0, int'(fill_valid), 0);

    // R6 / R8: back-to-back with all ways open: 0,1,2,3,0,1
    for (int k = 0; k < 6; k++) step(1, 0, '0, "R6 R8 rotation");
    step(0, 0, '0, "idle");

    // R2: upper bits ignored, lock ways 0 and 2
    step(0, 1, 32'hABCD_EF05, "R2 write");
    step(0, 0, '0, "idle");
    check_read("R2 readback");
    // R4: ptr=2, open 1,3 -> 3,1,3
    for (int k = 0; k < 3; k++) step(1, 0, '0, "R4 skip locked");
    step(0, 0, '0, "idle");

    // R5: all locked -> 3,3
    step(0, 1, 32'hFFFF_FFFF, "R5 write");
    check_read("R2 readback all");
    step(1, 0, '0, "R5 fallback");
    step(1, 0, '0, "R5 fallback");
    step(0, 0, '0, "idle");

    // R4: only way 0 open
    step(0, 1, 32'h0000_000E, "R4 write");
    step(1, 0, '0, "R4 single open");
    step(0, 0, '0, "idle");
    step(1, 0, '0, "R4 single open");

    // R7: same-cycle write uses old mask, next uses new (only way 3)
    step(1, 1, 32'h0000_0007, "R7 old mask");
    step(1, 0, '0, "R7 new mask");
    step(0, 0, '0, "idle");
    check_read("R2 readback after R7");

    // R3: sparse requests, unlock all, ptr continues from 0
    step(0, 1, 32'h0000_0000, "R3 write");
    step(1, 0, '0, "R3 sparse");
    step(0, 0, '0, "idle");
    step(0, 0, '0, "idle");
    step(1, 0, '0, "R3 sparse");
    step(0, 0, '0, "idle");
    step(0, 0, '0, "idle");
    finish_run();
  end
endmodule